// File: doc/BRIEF.md
# Pipeline Fetch and Redirect Controller

This block is the control plane of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It holds the program counter and the occupancy bit of each of the four inter-stage registers. Each cycle it decides which stages may move their instruction forward and issues a load strobe per register. It also picks the next fetch address and counts stalls, flushes and retired instructions. The datapath, the instruction memory, the predictor tables and the ALU live outside. They receive the block's strobes and return short per-stage summaries: whether the fetched word is a conditional branch, the jump kind and operands in decode, and the branch outcome at writeback.

Two operating modes are selected by `predOn`. With prediction on, a fetched conditional branch steers the PC to the buffered target when predicted taken. The chosen next address travels with the instruction through `fetchPredTarget`. At writeback, a mismatch between the predicted and actual target empties every stage and restarts fetch at the actual target. With prediction off, fetching a conditional branch freezes fetch until that branch retires, and writeback then supplies the next PC without a flush. In both modes, unconditional jumps redirect the PC from decode.

Top module: `pipe_flow_ctrl`

## Requirements
- R1: While reset is asserted, and just after it is released, `pc` is 4, `stageValid` is 0, all three counters are 0 and `idle` is 1.
- R2: `fetchEn` is 1 when `imemValid` is 1, the IF/ID register (stageValid bit 0) is empty or being vacated, and no hold, jump redirect or writeback redirect is active. After a plain fetch, `pc` rises by 4.
- R3: A stage advances only when the register below it is empty or vacating. Execute waits while `aluBusy` is 1 and memory waits while `memBusy` is 1. Each cycle in which IF/ID stays occupied and the pipeline is not being flushed increments `stallCount` by 1. Bit order: bit 0 IF/ID, bit 1 ID/EX, bit 2 EX/MEM, bit 3 MEM/WB, for both `stageValid` and `stageLoad`.
- R4: While `decHazard` is 1, the instruction in IF/ID stays there, nothing is fetched and `pc` holds.
- R5: When a JAL leaves decode, the next `pc` is `decPc + (decImm << 1)`. When a JALR leaves decode, the next `pc` is `(decRs1 + decImm)` with bit 0 cleared. No fetch takes place in that cycle.
- R6: With `predOn` = 1, fetching a conditional branch sets both `fetchPredTarget` and the next `pc` to `btbTarget` when `predTaken` is 1, and to `pc + 4` otherwise.
- R7: With `predOn` = 0, fetching a conditional branch blocks all further fetches until a branch is valid in MEM/WB with `wbIsBranch` = 1. In that cycle `pc` is loaded with `wbTarget`, no flush occurs, and fetch resumes in the next cycle.
- R8: With `predOn` = 1, a valid branch in MEM/WB whose `wbPredTarget` differs from `wbTarget` raises `flush` for that cycle. Next cycle `stageValid` is 0, `pc` equals `wbTarget` and `flushCount` is one higher. Matching targets cause no flush and no redirect.
- R9: When a flush and a decode jump occur in the same cycle, the flush target wins.
- R10: `regWrEn` is 1 only for a valid MEM/WB instruction with `wbRd` non-zero. `retireCount` increments once for every instruction leaving MEM/WB.
- R11: `idle` is 1 exactly when all four registers are empty and neither `aluBusy` nor `memBusy` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| predOn | input | 1 | 1 selects predicted mode, 0 selects fetch-blocking mode |
| imemValid | input | 1 | Instruction memory has a word at `pc` |
| fetchIsBranch | input | 1 | Word at `pc` is a conditional branch |
| predTaken | input | 1 | Direction prediction for the fetched branch |
| btbTarget | input | AW | Buffered target for the fetched branch |
| decIsJal | input | 1 | Instruction in decode is a PC-relative jump |
| decIsJalr | input | 1 | Instruction in decode is a register-indirect jump |
| decPc | input | AW | Address of the instruction in decode |
| decImm | input | AW | Immediate of the instruction in decode |
| decRs1 | input | AW | First source operand value in decode |
| decHazard | input | 1 | Register dependency check reports a hazard |
| aluBusy | input | 1 | Execute unit is occupied |
| memBusy | input | 1 | Data cache is occupied |
| wbIsBranch | input | 1 | MEM/WB instruction is a conditional branch |
| wbPredTarget | input | AW | Next address predicted when that branch was fetched |
| wbTarget | input | AW | Resolved next address of that branch |
| wbRd | input | 5 | Destination register of the MEM/WB instruction |
| pc | output | AW | Current fetch address |
| fetchEn | output | 1 | Fetch strobe; loads IF/ID |
| fetchPredTarget | output | AW | Next address chosen at fetch, to travel with the instruction |
| stageLoad | output | 4 | Load strobes of the four pipeline registers |
| stageValid | output | 4 | Occupancy of the four pipeline registers |
| flush | output | 1 | Clears the pipeline, cancels the ALU and resets dependency tracking |
| regWrEn | output | 1 | Register file write enable |
| stallCount | output | CW | Cycles with IF/ID blocked |
| flushCount | output | CW | Misprediction flushes |
| retireCount | output | CW | Retired instructions |
| idle | output | 1 | Pipeline empty and units free |

## Verification
The hardest situation to reach is a flush in MEM/WB that coincides with a jump leaving decode. It needs all four registers full at the moment the branch summary is driven. The stimulus streams sequential fetches from reset for exactly four cycles, so every register holds an instruction. It then raises the mismatching branch outcome and a jump summary in the same cycle and checks that the writeback target wins. The fetch-blocking mode is reached the same way: the bench waits until the frozen branch shows up in bit 3 of `stageValid` before it supplies the resolved target.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int NUM_PREG = 4;

  typedef struct packed {
    logic fetchEn;
    logic decAdv;
    logic exAdv;
    logic memAdv;
    logic retire;
    logic flush;
    logic resolve;
    logic jumpRedir;
    logic stall;
  } strobe_t;
endpackage

// File: rtl/pfc_counter.sv
module pfc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + W'(1);
  end
endmodule

// File: rtl/pfc_control.sv
module pfc_control
  import pfc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                predOn,
  input  logic                imemValid,
  input  logic                fetchIsBranch,
  input  logic                decIsJal,
  input  logic                decIsJalr,
  input  logic                decHazard,
  input  logic                aluBusy,
  input  logic                memBusy,
  input  logic                wbIsBranch,
  input  logic [AW-1:0]       wbPredTarget,
  input  logic [AW-1:0]       wbTarget,
  input  logic [4:0]          wbRd,
  output strobe_t             stb,
  output logic [NUM_PREG-1:0] vld,
  output logic                regWrEn,
  output logic                idle
);
  logic [NUM_PREG-1:0] vldNext;
  logic [NUM_PREG:0]   adv;
  logic                fetchHold;
  logic                wbBranch;
  logic                mispredict;
  logic                ifFree;

  assign wbBranch   = vld[NUM_PREG-1] & wbIsBranch;
  assign mispredict = wbBranch & predOn & (wbPredTarget != wbTarget);

  always_comb begin
    stb           = '0;
    stb.flush     = mispredict;
    stb.resolve   = wbBranch & ~predOn;
    stb.retire    = vld[3];
    stb.memAdv    = vld[2] & ~memBusy;
    stb.exAdv     = vld[1] & ~aluBusy & (~vld[2] | stb.memAdv);
    stb.decAdv    = vld[0] & ~decHazard & (~vld[1] | stb.exAdv);
    stb.jumpRedir = stb.decAdv & (decIsJal | decIsJalr);
    ifFree        = ~vld[0] | stb.decAdv;
    stb.fetchEn   = ifFree & imemValid & ~fetchHold & ~stb.jumpRedir
                    & ~stb.flush & ~stb.resolve;
    stb.stall     = vld[0] & ~stb.decAdv & ~stb.flush;
  end

  assign adv = {stb.retire, stb.memAdv, stb.exAdv, stb.decAdv, stb.fetchEn};

  // Each register fills from the stage above and drains into the stage below.
  for (genvar i = 0; i < NUM_PREG; i++) begin : g_preg
    assign vldNext[i] = adv[i] | (vld[i] & ~adv[i+1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vld <= '0;
    else if (stb.flush) vld <= '0;
    else                vld <= vldNext;
  end

  // Fetch-blocking mode: freeze after a conditional branch until it retires.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          fetchHold <= 1'b0;
    else if (stb.flush || stb.resolve)   fetchHold <= 1'b0;
    else if (stb.fetchEn && fetchIsBranch && !predOn) fetchHold <= 1'b1;
  end

  assign regWrEn = vld[3] & (wbRd != 5'd0);
  assign idle    = ~|vld & ~aluBusy & ~memBusy;
endmodule

// File: rtl/pfc_datapath.sv
module pfc_datapath
  import pfc_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          CW       = 16,
  parameter logic [31:0] RESET_PC = 32'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       stb,
  input  logic          predOn,
  input  logic          fetchIsBranch,
  input  logic          predTaken,
  input  logic [AW-1:0] btbTarget,
  input  logic          decIsJalr,
  input  logic [AW-1:0] decPc,
  input  logic [AW-1:0] decImm,
  input  logic [AW-1:0] decRs1,
  input  logic [AW-1:0] wbTarget,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] fetchNext,
  output logic [CW-1:0] stallCount,
  output logic [CW-1:0] flushCount,
  output logic [CW-1:0] retireCount
);
  localparam int NCNT = 3;

  logic [AW-1:0]   jumpTarget;
  logic [AW-1:0]   seqPc;
  logic [NCNT-1:0] cntInc;
  logic [CW-1:0]   cnt [NCNT];

  assign seqPc      = pc + AW'(4);
  assign fetchNext  = (fetchIsBranch && predOn && predTaken) ? btbTarget : seqPc;
  assign jumpTarget = decIsJalr ? ((decRs1 + decImm) & ~AW'(1))
                                : (decPc + (decImm << 1));

  // Writeback redirect outranks decode jump, which outranks fetch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pc <= AW'(RESET_PC);
    else if (stb.flush || stb.resolve) pc <= wbTarget;
    else if (stb.jumpRedir)            pc <= jumpTarget;
    else if (stb.fetchEn)              pc <= fetchNext;
  end

  assign cntInc = {stb.retire, stb.flush, stb.stall};

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    pfc_counter #(.W(CW)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (cntInc[i]),
      .count(cnt[i])
    );
  end

  assign stallCount  = cnt[0];
  assign flushCount  = cnt[1];
  assign retireCount = cnt[2];
endmodule

// File: rtl/pipe_flow_ctrl.sv
module pipe_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          CW       = 16,
  parameter logic [31:0] RESET_PC = 32'd4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                predOn,
  input  logic                imemValid,
  input  logic                fetchIsBranch,
  input  logic                predTaken,
  input  logic [AW-1:0]       btbTarget,
  input  logic                decIsJal,
  input  logic                decIsJalr,
  input  logic [AW-1:0]       decPc,
  input  logic [AW-1:0]       decImm,
  input  logic [AW-1:0]       decRs1,
  input  logic                decHazard,
  input  logic                aluBusy,
  input  logic                memBusy,
  input  logic                wbIsBranch,
  input  logic [AW-1:0]       wbPredTarget,
  input  logic [AW-1:0]       wbTarget,
  input  logic [4:0]          wbRd,
  output logic [AW-1:0]       pc,
  output logic                fetchEn,
  output logic [AW-1:0]       fetchPredTarget,
  output logic [NUM_PREG-1:0] stageLoad,
  output logic [NUM_PREG-1:0] stageValid,
  output logic                flush,
  output logic                regWrEn,
  output logic [CW-1:0]       stallCount,
  output logic [CW-1:0]       flushCount,
  output logic [CW-1:0]       retireCount,
  output logic                idle
);
  strobe_t stb;

  pfc_control #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .predOn       (predOn),
    .imemValid    (imemValid),
    .fetchIsBranch(fetchIsBranch),
    .decIsJal     (decIsJal),
    .decIsJalr    (decIsJalr),
    .decHazard    (decHazard),
    .aluBusy      (aluBusy),
    .memBusy      (memBusy),
    .wbIsBranch   (wbIsBranch),
    .wbPredTarget (wbPredTarget),
    .wbTarget     (wbTarget),
    .wbRd         (wbRd),
    .stb          (stb),
    .vld          (stageValid),
    .regWrEn      (regWrEn),
    .idle         (idle)
  );

  pfc_datapath #(.AW(AW), .CW(CW), .RESET_PC(RESET_PC)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .predOn       (predOn),
    .fetchIsBranch(fetchIsBranch),
    .predTaken    (predTaken),
    .btbTarget    (btbTarget),
    .decIsJalr    (decIsJalr),
    .decPc        (decPc),
    .decImm       (decImm),
    .decRs1       (decRs1),
    .wbTarget     (wbTarget),
    .pc           (pc),
    .fetchNext    (fetchPredTarget),
    .stallCount   (stallCount),
    .flushCount   (flushCount),
    .retireCount  (retireCount)
  );

  assign fetchEn   = stb.fetchEn;
  assign flush     = stb.flush;
  assign stageLoad = {stb.memAdv, stb.exAdv, stb.decAdv, stb.fetchEn};
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int          AW       = 32,
  parameter logic [31:0] RESET_PC = 32'd4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc,
  input logic          fetchEn,
  input logic [3:0]    stageLoad,
  input logic [3:0]    stageValid,
  input logic          flush,
  input logic          regWrEn,
  input logic          idle,
  input logic          memBusy,
  input logic          decHazard,
  input logic          predOn,
  input logic          fetchIsBranch,
  input logic          predTaken,
  input logic          wbIsBranch
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc == AW'(RESET_PC));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchEn && !(fetchIsBranch && predOn && predTaken) |=> pc == $past(pc) + AW'(4));

  // R3
  fetch_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchEn |-> (!stageValid[0] || stageLoad[1]));

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stageValid[2] && memBusy && !flush |=> stageValid[2]);

  // R4
  hazard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stageValid[0] && decHazard && !flush && !(stageValid[3] && wbIsBranch)
    |=> $stable(pc) && stageValid[0]);

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> stageValid == 4'b0000);

  // R10
  wr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> stageValid[3]);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !regWrEn);
endmodule

bind pipe_flow_ctrl pfc_checker #(.AW(AW), .RESET_PC(RESET_PC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pc           (pc),
  .fetchEn      (fetchEn),
  .stageLoad    (stageLoad),
  .stageValid   (stageValid),
  .flush        (flush),
  .regWrEn      (regWrEn),
  .idle         (idle),
  .memBusy      (memBusy),
  .decHazard    (decHazard),
  .predOn       (predOn),
  .fetchIsBranch(fetchIsBranch),
  .predTaken    (predTaken),
  .wbIsBranch   (wbIsBranch)
);

// File: tb/pipe_flow_ctrl_test.sv
module pipe_flow_ctrl_test;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          predOn, imemValid, fetchIsBranch, predTaken;
  logic [AW-1:0] btbTarget, decPc, decImm, decRs1, wbPredTarget, wbTarget;
  logic          decIsJal, decIsJalr, decHazard, aluBusy, memBusy, wbIsBranch;
  logic [4:0]    wbRd;
  logic [AW-1:0] pc, fetchPredTarget;
  logic          fetchEn, flush, regWrEn, idle;
  logic [3:0]    stageLoad, stageValid;
  logic [CW-1:0] stallCount, flushCount, retireCount;

  int            nRun = 0;
  int            nFail = 0;
  logic [AW-1:0] expQ[$];
  bit            track = 0;
  int            wrCnt = 0;
  logic [CW-1:0] s0;

  always #4 clk = ~clk;

  pipe_flow_ctrl #(.AW(AW), .CW(CW)) uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected fetch addresses as the design fetches.
  always @(negedge clk) begin
    #2;
    if (regWrEn) wrCnt++;
    if (track && fetchEn) begin
      nRun++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R2 actual=%0d expected=none (unexpected fetch)", pc);
      end else begin
        logic [AW-1:0] e;
        e = expQ.pop_front();
        if (pc !== e) begin
          nFail++;
          $display("FAIL R2 actual=%0d expected=%0d", pc, e);
        end
      end
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    predOn = 1'b1; imemValid = 1'b0; fetchIsBranch = 1'b0; predTaken = 1'b0;
    btbTarget = '0; decIsJal = 1'b0; decIsJalr = 1'b0; decPc = '0; decImm = '0;
    decRs1 = '0; decHazard = 1'b0; aluBusy = 1'b0; memBusy = 1'b0;
    wbIsBranch = 1'b0; wbPredTarget = '0; wbTarget = '0; wbRd = 5'd0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    chk("R1 pc", pc, 4);
    chk("R1 valid", stageValid, 0);
    chk("R1 idle", idle, 1);
    chk("R1 counters", {stallCount, flushCount, retireCount}, 0);

    // R2 sequential fetch through the scoreboard; R10/R11 on drain
    for (int k = 0; k < 5; k++) expQ.push_back(AW'(4 + 4 * k));
    wrCnt = 0; wbRd = 5'd3; track = 1; imemValid = 1'b1;
    step(1);
    chk("R11 busy", idle, 0);
    step(4);
    imemValid = 1'b0;
    chk("R2 queue drained", expQ.size(), 0);
    step(8);
    track = 0;
    chk("R11 idle after drain", idle, 1);
    chk("R10 retired", retireCount, 5);
    chk("R10 writes", wrCnt, 5);
    wbRd = 5'd0; imemValid = 1'b1;
    step(3);
    imemValid = 1'b0;
    step(8);
    chk("R10 rd0 suppressed", wrCnt, 5);
    chk("R10 retired rd0", retireCount, 8);

    // R3 backpressure from memory, then ALU
    doReset();
    imemValid = 1'b1; memBusy = 1'b1;
    step(6);
    chk("R3 full", stageValid, 4'b0111);
    chk("R3 no fetch", fetchEn, 0);
    chk("R3 pc hold", pc, 16);
    s0 = stallCount;
    step(3);
    chk("R3 stall count", stallCount, s0 + 3);
    memBusy = 1'b0; aluBusy = 1'b1;
    step(2);
    chk("R3 alu hold", stageValid, 4'b0011);
    chk("R3 alu no fetch", fetchEn, 0);
    aluBusy = 1'b0; #1;
    chk("R3 resume", fetchEn, 1);

    // R4 dependency hazard
    doReset();
    imemValid = 1'b1; decHazard = 1'b1;
    step(4);
    chk("R4 held", stageValid, 4'b0001);
    chk("R4 no fetch", fetchEn, 0);
    chk("R4 pc", pc, 8);
    decHazard = 1'b0; #1;
    chk("R4 release", fetchEn, 1);

    // R5 jumps from decode
    doReset();
    imemValid = 1'b1;
    step(1);
    decIsJal = 1'b1; decPc = 4; decImm = 16; #1;
    chk("R5 jal no fetch", fetchEn, 0);
    step(1);
    decIsJal = 1'b0;
    chk("R5 jal pc", pc, 36);
    chk("R5 jal valid", stageValid, 4'b0010);
    step(1);
    decIsJalr = 1'b1; decRs1 = 101; decImm = 10;
    step(1);
    decIsJalr = 1'b0;
    chk("R5 jalr pc", pc, 110);

    // R6 predicted branches
    doReset();
    expQ.push_back(4); expQ.push_back(200);
    track = 1; imemValid = 1'b1; fetchIsBranch = 1'b1; predTaken = 1'b1; btbTarget = 200; #1;
    chk("R6 taken target", fetchPredTarget, 200);
    step(1);
    chk("R6 taken pc", pc, 200);
    predTaken = 1'b0; #1;
    chk("R6 not taken target", fetchPredTarget, 204);
    step(1);
    track = 0; imemValid = 1'b0; fetchIsBranch = 1'b0;
    chk("R6 not taken pc", pc, 204);
    chk("R6 queue drained", expQ.size(), 0);

    // R7 fetch-blocking mode
    doReset();
    predOn = 1'b0; imemValid = 1'b1; fetchIsBranch = 1'b1;
    step(1);
    fetchIsBranch = 1'b0; #1;
    chk("R7 blocked", fetchEn, 0);
    step(3);
    chk("R7 at writeback", stageValid, 4'b1000);
    wbIsBranch = 1'b1; wbTarget = 80; #1;
    chk("R7 still blocked", fetchEn, 0);
    chk("R7 no flush", flush, 0);
    step(1);
    wbIsBranch = 1'b0; #1;
    chk("R7 pc", pc, 80);
    chk("R7 resumed", fetchEn, 1);
    chk("R7 flush count", flushCount, 0);

    // R8/R9 mispredict flush colliding with a decode jump
    doReset();
    imemValid = 1'b1;
    step(4);
    chk("R8 full", stageValid, 4'b1111);
    wbIsBranch = 1'b1; wbPredTarget = 40; wbTarget = 300;
    decIsJal = 1'b1; decPc = 8; decImm = 4; #1;
    chk("R8 flush", flush, 1);
    step(1);
    wbIsBranch = 1'b0; decIsJal = 1'b0;
    chk("R9 flush beats jump", pc, 300);
    chk("R8 emptied", stageValid, 0);
    chk("R8 flush count", flushCount, 1);
    step(4);
    wbIsBranch = 1'b1; wbPredTarget = 500; wbTarget = 500; #1;
    chk("R8 match no flush", flush, 0);
    step(1);
    wbIsBranch = 1'b0;
    chk("R8 match keeps stages", stageValid, 4'b1111);
    chk("R8 match pc", pc, 320);
    chk("R8 match count", flushCount, 1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule